// File: doc/BRIEF.md
# Outstanding Miss Fence Unit

This unit keeps count of memory requests that have left the chip and still wait for their reply. It uses that count to carry out a full fence (sync). A one-cycle pulse on `miss_send_i` marks each departing miss, and a pulse on `miss_reply_i` marks each returning reply. The live count is visible on `outstanding_o`. The counter is 5 bits wide by default and saturates at both ends. It raises a sticky error flag on any overflow or underflow attempt.

A sync request is accepted when `sync_ready_o` is high. While it is pending, issue from the address queue is held off through `issue_en_o`. The fence clears once the outstanding count is zero and the core reports that all older memory operations have committed. In the cycle issue is re-enabled, `sync_done_o` pulses for one cycle. Only one sync can be pending. A second request made while one is pending is refused through `sync_ready_o` and has no effect.

Top module: `miss_fence_unit`

## Requirements
- R1: A cycle with `miss_send_i`=1 and `miss_reply_i`=0 raises `outstanding_o` by one on the next clock, unless it is already at its maximum (31 by default).
- R2: A cycle with `miss_reply_i`=1 and `miss_send_i`=0 lowers `outstanding_o` by one on the next clock, unless it is already zero.
- R3: When `miss_send_i` and `miss_reply_i` are both 1 in the same cycle, `outstanding_o` keeps its value.
- R4: A departure at the maximum count leaves the count at the maximum and sets `cnt_err_o`.
- R5: A reply at count zero leaves the count at zero and sets `cnt_err_o`. Once set, `cnt_err_o` stays 1 until reset.
- R6: After reset, `outstanding_o`=0, `issue_en_o`=1, `sync_ready_o`=1, `sync_done_o`=0 and `cnt_err_o`=0.
- R7: A sync accepted while the count is non-zero, or while `older_committed_i`=0, drives `issue_en_o` to 0 from the next cycle onward.
- R8: While a sync is pending, `issue_en_o` returns to 1 only on the clock after a cycle in which the count is zero and `older_committed_i`=1.
- R9: `sync_done_o` is 1 for exactly one cycle, and that cycle is the one in which issue is re-enabled.
- R10: A sync accepted while the count is zero and `older_committed_i`=1 produces `sync_done_o`=1 in the next cycle, and `issue_en_o` never drops.
- R11: While a sync is pending, `sync_ready_o`=0. A `sync_req_i` made in that state is ignored and produces no extra `sync_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_send_i | input | 1 | One pulse per miss request leaving the chip |
| miss_reply_i | input | 1 | One pulse per returning reply |
| sync_req_i | input | 1 | Request to start a full fence |
| older_committed_i | input | 1 | All older memory operations have committed |
| issue_en_o | output | 1 | Address queue may issue |
| sync_ready_o | output | 1 | A new sync request can be accepted |
| sync_done_o | output | 1 | One-cycle pulse when a fence completes |
| outstanding_o | output | CNT_W | Current count of outstanding misses |
| cnt_err_o | output | 1 | Sticky counter overflow or underflow flag |

## Verification
A miss departure and a reply can land in the same cycle. The bench provokes this with a nonzero count and judges it by the count staying unchanged. A sync request can also arrive in the very cycle its clearing condition already holds. The bench provokes this with the count drained and commit reported, and judges it by a done pulse on the next clock while issue stays enabled. A third case is a request that lands while another sync is pending. The bench checks that this request produces neither a second done pulse nor a change in issue.

// File: rtl/miss_fence_pkg.sv
package miss_fence_pkg;
  typedef enum logic {
    FENCE_IDLE = 1'b0,
    FENCE_WAIT = 1'b1
  } fence_state_e;
endpackage

// File: rtl/miss_counter.sv
module miss_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    unique case ({inc_i, dec_i})
      2'b10: begin
        if (cnt_q == CntMax) err_d = 1'b1;
        else                 cnt_d = cnt_q + 1'b1;
      end
      2'b01: begin
        if (cnt_q == '0) err_d = 1'b1;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
  assign err_o  = err_q;
endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import miss_fence_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_req_i,
  input  logic cnt_zero_i,
  input  logic committed_i,
  output logic issue_en_o,
  output logic ready_o,
  output logic done_o
);
  fence_state_e state_q, state_d;
  logic         done_q, done_d;
  logic         accept, clear;

  assign accept = sync_req_i && (state_q == FENCE_IDLE);
  assign clear  = cnt_zero_i && committed_i;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    unique case (state_q)
      FENCE_IDLE: begin
        if (accept) begin
          // already drained: finish without blocking issue
          if (clear) done_d  = 1'b1;
          else       state_d = FENCE_WAIT;
        end
      end
      FENCE_WAIT: begin
        if (clear) begin
          state_d = FENCE_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = FENCE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FENCE_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign issue_en_o = (state_q == FENCE_IDLE);
  assign ready_o    = (state_q == FENCE_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/miss_fence_unit.sv
module miss_fence_unit #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_send_i,
  input  logic             miss_reply_i,
  input  logic             sync_req_i,
  input  logic             older_committed_i,
  output logic             issue_en_o,
  output logic             sync_ready_o,
  output logic             sync_done_o,
  output logic [CNT_W-1:0] outstanding_o,
  output logic             cnt_err_o
);
  logic cnt_zero;

  miss_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (miss_send_i),
    .dec_i  (miss_reply_i),
    .cnt_o  (outstanding_o),
    .zero_o (cnt_zero),
    .err_o  (cnt_err_o)
  );

  sync_ctrl u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_req_i  (sync_req_i),
    .cnt_zero_i  (cnt_zero),
    .committed_i (older_committed_i),
    .issue_en_o  (issue_en_o),
    .ready_o     (sync_ready_o),
    .done_o      (sync_done_o)
  );
endmodule

// File: rtl/miss_fence_chk.sv
module miss_fence_chk #(
  parameter int unsigned CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             miss_send_i,
  input logic             miss_reply_i,
  input logic             sync_req_i,
  input logic             older_committed_i,
  input logic             issue_en_o,
  input logic             sync_ready_o,
  input logic             sync_done_o,
  input logic [CNT_W-1:0] outstanding_o,
  input logic             cnt_err_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  assert_inc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_send_i && !miss_reply_i && outstanding_o != CntMax)
      |=> outstanding_o == $past(outstanding_o) + 1'b1);

  assert_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_reply_i && !miss_send_i && outstanding_o != '0)
      |=> outstanding_o == $past(outstanding_o) - 1'b1);

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_send_i && miss_reply_i) |=> $stable(outstanding_o));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_send_i && !miss_reply_i && outstanding_o == CntMax)
      |=> (outstanding_o == CntMax) && cnt_err_o);

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_reply_i && !miss_send_i && outstanding_o == '0)
      |=> (outstanding_o == '0) && cnt_err_o);

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_err_o |=> cnt_err_o);

  assert_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_req_i && sync_ready_o && !(outstanding_o == '0 && older_committed_i))
      |=> !issue_en_o);

  assert_resume_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_en_o && outstanding_o == '0 && older_committed_i)
      |=> issue_en_o && sync_done_o);

  assert_stay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_en_o && !(outstanding_o == '0 && older_committed_i)) |=> !issue_en_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_done_o |-> issue_en_o);

  assert_fast_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_req_i && sync_ready_o && outstanding_o == '0 && older_committed_i)
      |=> sync_done_o && issue_en_o);

  assert_not_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_en_o |-> !sync_ready_o);
endmodule

bind miss_fence_unit miss_fence_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .miss_send_i       (miss_send_i),
  .miss_reply_i      (miss_reply_i),
  .sync_req_i        (sync_req_i),
  .older_committed_i (older_committed_i),
  .issue_en_o        (issue_en_o),
  .sync_ready_o      (sync_ready_o),
  .sync_done_o       (sync_done_o),
  .outstanding_o     (outstanding_o),
  .cnt_err_o         (cnt_err_o)
);

// File: tb/miss_fence_unit_tb_top.sv
`timescale 1ns/1ps
module miss_fence_unit_tb_top;
  localparam int unsigned CNT_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             miss_send_i = 1'b0;
  logic             miss_reply_i = 1'b0;
  logic             sync_req_i = 1'b0;
  logic             older_committed_i = 1'b0;
  logic             issue_en_o, sync_ready_o, sync_done_o, cnt_err_o;
  logic [CNT_W-1:0] outstanding_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  miss_fence_unit #(.CNT_W(CNT_W)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive after falling edge, sample just after rising edge
  task automatic drive(input logic s, input logic r, input logic q, input logic c);
    @(negedge clk_i);
    miss_send_i = s; miss_reply_i = r; sync_req_i = q; older_committed_i = c;
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    miss_send_i = 0; miss_reply_i = 0; sync_req_i = 0; older_committed_i = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check("R6 outstanding", int'(outstanding_o), 0);
    check("R6 issue_en", int'(issue_en_o), 1);
    check("R6 ready", int'(sync_ready_o), 1);
    check("R6 done", int'(sync_done_o), 0);
    check("R6 err", int'(cnt_err_o), 0);
  endtask

  task automatic t_count_and_both();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      drive(1, 0, 0, 0); tick();
    end
    check("R1 count after three sends", int'(outstanding_o), 3);
    drive(1, 1, 0, 0); tick();
    check("R3 send+reply same cycle", int'(outstanding_o), 3);
    drive(0, 1, 0, 0); tick();
    check("R2 reply decrements", int'(outstanding_o), 2);
    drive(0, 0, 0, 0); tick();
  endtask

  task automatic t_sync_blocked();
    do_reset();
    for (int i = 0; i < 2; i++) begin
      drive(1, 0, 0, 1); tick();
    end
    drive(0, 0, 1, 1); tick();
    check("R7 issue blocked", int'(issue_en_o), 0);
    check("R11 not ready while pending", int'(sync_ready_o), 0);
    // second request while pending must be ignored
    drive(0, 1, 1, 0); tick();
    check("R11 still not ready", int'(sync_ready_o), 0);
    drive(0, 1, 0, 0); tick();
    check("R2 drained to zero", int'(outstanding_o), 0);
    drive(0, 0, 0, 0); tick();
    check("R8 held while commit low", int'(issue_en_o), 0);
    check("R9 no done while held", int'(sync_done_o), 0);
    drive(0, 0, 0, 1); tick();
    check("R8 issue resumes", int'(issue_en_o), 1);
    check("R9 done in resume cycle", int'(sync_done_o), 1);
    drive(0, 0, 0, 1); tick();
    check("R9 done lasts one cycle", int'(sync_done_o), 0);
    check("R11 ignored request made no fence", int'(issue_en_o), 1);
    tick();
    check("R11 no extra done", int'(sync_done_o), 0);
  endtask

  task automatic t_sync_fast();
    do_reset();
    drive(0, 0, 1, 1); tick();
    check("R10 immediate done", int'(sync_done_o), 1);
    check("R10 issue kept", int'(issue_en_o), 1);
    drive(0, 0, 0, 1); tick();
    check("R9 fast done one cycle", int'(sync_done_o), 0);
  endtask

  task automatic t_zero_not_committed();
    do_reset();
    drive(0, 0, 1, 0); tick();
    check("R7 blocked with zero count, no commit", int'(issue_en_o), 0);
    drive(0, 0, 0, 1); tick();
    check("R8 resume on commit", int'(issue_en_o), 1);
    check("R9 done on commit", int'(sync_done_o), 1);
    drive(0, 0, 0, 0); tick();
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 31; i++) begin
      drive(1, 0, 0, 0); tick();
    end
    check("R1 reaches max", int'(outstanding_o), 31);
    check("R4 no error at max", int'(cnt_err_o), 0);
    drive(1, 0, 0, 0); tick();
    check("R4 saturates", int'(outstanding_o), 31);
    check("R4 error set", int'(cnt_err_o), 1);
    drive(0, 0, 0, 0); tick();
  endtask

  task automatic t_underflow();
    do_reset();
    drive(0, 1, 0, 0); tick();
    check("R5 stays zero", int'(outstanding_o), 0);
    check("R5 error set", int'(cnt_err_o), 1);
    drive(1, 0, 0, 0); tick();
    check("R5 error sticky", int'(cnt_err_o), 1);
    drive(0, 0, 0, 0); tick();
  endtask

  initial begin
    t_reset_state();
    t_count_and_both();
    t_sync_blocked();
    t_sync_fast();
    t_zero_not_committed();
    t_overflow();
    t_underflow();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule